// File: doc/BRIEF.md
# Synchronized Clock Stop Controller

This block sits between two free-running clock sources and their output trees. One source is the CPU clock, the other the PCI clock, which runs at half the CPU rate. It stops and restarts a group of CPU clock outputs and a group of gated PCI clock outputs in response to two active-low stop requests. The requests may change at any time, with no relation to either clock. One extra PCI output is never gated by a stop request. An active-low power-down input overrides everything. It parks every output low and raises a flag that tells the analog side to turn off the oscillator and the PLLs.

The stop requests count only while the active-low mode input is low. With mode high, the board uses those pins for other purposes, so the requests are ignored. Each request is brought into the domain of the clock it gates. The gate itself changes only while that clock is low. As a result, a stopped output always parks low, and every high pulse that does appear has full width. Leaving reset or power-down restarts the outputs only after the domain resets and the request synchronizers have cleared.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While `rst_n` is low, every clock output is low. After `rst_n` rises shortly after a CPU rising edge, with all stops inactive, the CPU outputs show their first pulse on the 5th CPU rising edge that follows.
- R2: While `mode_n` is 0 and `cpu_stop_n` is 0, all bits of `cpu_clk_o` stay low.
- R3: When `cpu_stop_n` falls shortly after a CPU rising edge, exactly two more CPU pulses appear. When it rises shortly after a CPU rising edge, the first new pulse comes on the 3rd CPU rising edge that follows.
- R4: While `mode_n` is 0 and `pci_stop_n` is 0, all bits of `pci_clk_o` stay low, and `pci_free_o` keeps pulsing on every PCI rising edge.
- R5: When `pci_stop_n` falls shortly after a PCI rising edge, exactly one more gated PCI pulse appears. When it rises shortly after a PCI rising edge, the first new pulse comes on the 2nd PCI rising edge that follows.
- R6: While `mode_n` is 1, both stop inputs have no effect, and all CPU and gated PCI outputs pulse on every rising edge of their clock.
- R7: While `pwr_dn_n` is 0, every output clock, `pci_free_o` included, is low and `osc_off_o` is 1, whatever the stop and mode inputs are. `osc_off_o` is 0 while `pwr_dn_n` is 1.
- R8: When `pwr_dn_n` rises shortly after a rising edge of the relevant clock, the first CPU pulse comes on the 5th CPU rising edge that follows. The first gated and free PCI pulses come on the 4th PCI rising edge that follows.
- R9: Output clocks change only while their source clock is low. Each output pulse is high for the whole high phase of its source clock, all bits of a group move together, and every output is low during the low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk_i | input | 1 | Source CPU clock |
| pci_clk_i | input | 1 | Source PCI clock (half CPU rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn_n | input | 1 | Asynchronous active-low power-down |
| mode_n | input | 1 | Active-low enable for the stop inputs |
| cpu_stop_n | input | 1 | Asynchronous active-low CPU stop request |
| pci_stop_n | input | 1 | Asynchronous active-low PCI stop request |
| cpu_clk_o | output | NUM_CPU | Gated CPU clock outputs |
| pci_clk_o | output | NUM_PCI | Gated PCI clock outputs |
| pci_free_o | output | 1 | PCI clock output unaffected by stop requests |
| osc_off_o | output | 1 | High while the oscillator and PLLs are to be off |

## Verification
The CPU path has two synchronizer flops and a falling-edge gate register. A stop applied just after a CPU rising edge therefore lets exactly two pulses through, and a restart shows its first pulse on the third edge. The PCI path has a single flop ahead of its falling-edge gate, so its figures are one pulse and the second edge. Release from reset or power-down adds the two flops of the domain reset synchronizer. The bench drives every request 0.2 ns after a rising edge and then counts output pulses edge by edge over a fixed window. A pulse counts when the output is seen in the middle of the high phase. The same pass compares early-high, late-high and low-phase samples to detect runt pulses. A sweep over all sixteen combinations of power-down, mode and the two stops waits six PCI cycles before counting, which is longer than the slowest latency.

// File: rtl/ckstp_pkg.sv
`timescale 1ns/1ps
package ckstp_pkg;

  typedef enum logic {
    GATE_CLOSED = 1'b0,
    GATE_OPEN   = 1'b1
  } gate_e;

  // A clock group runs unless the stop function is enabled (mode low)
  // and its stop request is active (low).
  function automatic logic run_request(input logic mode_n, input logic stop_n);
    return mode_n | stop_n;
  endfunction

endpackage

// File: rtl/ckstp_rst_sync.sv
`timescale 1ns/1ps
module ckstp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic srst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  // Shift ones in; asserted asynchronously, released after STAGES edges.
  always_comb begin
    chain_d = (chain_q << 1) | {{(STAGES-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/ckstp_gate_lane.sv
`timescale 1ns/1ps
module ckstp_gate_lane
  import ckstp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WIDTH       = 4
) (
  input  logic             clk_i,
  input  logic             srst_n_i,
  input  logic             run_async_i,
  output logic [WIDTH-1:0] clk_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  gate_e                  gate_q;
  gate_e                  gate_d;
  logic                   gated_clk;

  // Synchronizer chain on the rising edge of the gated clock's own source.
  if (SYNC_STAGES == 1) begin : g_single
    assign sync_d = run_async_i;
  end else begin : g_chain
    assign sync_d = {sync_q[SYNC_STAGES-2:0], run_async_i};
  end

  always_ff @(posedge clk_i or negedge srst_n_i) begin
    if (!srst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  // Gate enable moves only on the falling edge, so the AND below can
  // never cut a high phase short or open in the middle of one.
  always_comb begin
    gate_d = sync_q[SYNC_STAGES-1] ? GATE_OPEN : GATE_CLOSED;
  end

  always_ff @(negedge clk_i or negedge srst_n_i) begin
    if (!srst_n_i) begin
      gate_q <= GATE_CLOSED;
    end else begin
      gate_q <= gate_d;
    end
  end

  assign gated_clk = clk_i & (gate_q == GATE_OPEN);

  for (genvar i = 0; i < WIDTH; i++) begin : g_fanout
    assign clk_o[i] = gated_clk;
  end

endmodule

// File: rtl/clk_stop_ctrl.sv
`timescale 1ns/1ps
module clk_stop_ctrl
  import ckstp_pkg::*;
#(
  parameter int unsigned NUM_CPU     = 4,
  parameter int unsigned NUM_PCI     = 6,
  parameter int unsigned CPU_SYNC    = 2,
  parameter int unsigned PCI_SYNC    = 1,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic               cpu_clk_i,
  input  logic               pci_clk_i,
  input  logic               rst_n,
  input  logic               pwr_dn_n,
  input  logic               mode_n,
  input  logic               cpu_stop_n,
  input  logic               pci_stop_n,
  output logic [NUM_CPU-1:0] cpu_clk_o,
  output logic [NUM_PCI-1:0] pci_clk_o,
  output logic               pci_free_o,
  output logic               osc_off_o
);

  localparam int unsigned FREE_WIDTH = 1;

  logic arst_n;
  logic cpu_srst_n;
  logic pci_srst_n;
  logic cpu_run;
  logic pci_run;
  logic [FREE_WIDTH-1:0] free_clk;

  // Power-down acts as a reset: it closes every gate at once and the
  // gates reopen only after the domain reset and synchronizers clear.
  assign arst_n  = rst_n & pwr_dn_n;
  assign cpu_run = run_request(mode_n, cpu_stop_n);
  assign pci_run = run_request(mode_n, pci_stop_n);

  ckstp_rst_sync #(.STAGES(RST_STAGES)) u_cpu_rst (
    .clk_i    (cpu_clk_i),
    .arst_n_i (arst_n),
    .srst_n_o (cpu_srst_n)
  );

  ckstp_rst_sync #(.STAGES(RST_STAGES)) u_pci_rst (
    .clk_i    (pci_clk_i),
    .arst_n_i (arst_n),
    .srst_n_o (pci_srst_n)
  );

  ckstp_gate_lane #(.SYNC_STAGES(CPU_SYNC), .WIDTH(NUM_CPU)) u_cpu_lane (
    .clk_i       (cpu_clk_i),
    .srst_n_i    (cpu_srst_n),
    .run_async_i (cpu_run),
    .clk_o       (cpu_clk_o)
  );

  ckstp_gate_lane #(.SYNC_STAGES(PCI_SYNC), .WIDTH(NUM_PCI)) u_pci_lane (
    .clk_i       (pci_clk_i),
    .srst_n_i    (pci_srst_n),
    .run_async_i (pci_run),
    .clk_o       (pci_clk_o)
  );

  // The free lane shares the gating structure but its request is tied
  // to run, so only reset and power-down ever close it.
  ckstp_gate_lane #(.SYNC_STAGES(PCI_SYNC), .WIDTH(FREE_WIDTH)) u_free_lane (
    .clk_i       (pci_clk_i),
    .srst_n_i    (pci_srst_n),
    .run_async_i (1'b1),
    .clk_o       (free_clk)
  );

  assign pci_free_o = free_clk[0];
  assign osc_off_o  = ~pwr_dn_n;

endmodule

// File: rtl/clk_stop_ctrl_chk.sv
`timescale 1ns/1ps
module clk_stop_ctrl_chk #(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned NUM_PCI = 6
) (
  input logic               cpu_clk_i,
  input logic               pci_clk_i,
  input logic               rst_n,
  input logic               pwr_dn_n,
  input logic               mode_n,
  input logic               cpu_stop_n,
  input logic               pci_stop_n,
  input logic [NUM_CPU-1:0] cpu_clk_o,
  input logic [NUM_PCI-1:0] pci_clk_o,
  input logic               pci_free_o
);

  logic cpu_hold;
  logic pci_hold;
  logic cpu_mode_off;
  logic pci_mode_off;
  logic powered;

  assign cpu_hold     = rst_n && pwr_dn_n && !mode_n && !cpu_stop_n;
  assign pci_hold     = rst_n && pwr_dn_n && !mode_n && !pci_stop_n;
  assign cpu_mode_off = rst_n && pwr_dn_n && mode_n;
  assign pci_mode_off = rst_n && pwr_dn_n && mode_n;
  assign powered      = rst_n && pwr_dn_n;

  // Sampled at a falling edge, an output shows its high-phase value.

  // R2
  cpu_stop_hold_chk: assert property (@(negedge cpu_clk_i) disable iff (!rst_n || !pwr_dn_n)
    (cpu_hold && $past(cpu_hold, 1) && $past(cpu_hold, 2) && $past(cpu_hold, 3))
      |-> (cpu_clk_o == '0));

  // R4
  pci_stop_hold_chk: assert property (@(negedge pci_clk_i) disable iff (!rst_n || !pwr_dn_n)
    (pci_hold && $past(pci_hold, 1) && $past(pci_hold, 2))
      |-> (pci_clk_o == '0));

  // R4
  free_runs_chk: assert property (@(negedge pci_clk_i) disable iff (!rst_n || !pwr_dn_n)
    (powered && $past(powered, 1) && $past(powered, 2) && $past(powered, 3) && $past(powered, 4))
      |-> pci_free_o);

  // R6
  cpu_mode_ignore_chk: assert property (@(negedge cpu_clk_i) disable iff (!rst_n || !pwr_dn_n)
    (cpu_mode_off && $past(cpu_mode_off, 1) && $past(cpu_mode_off, 2) && $past(cpu_mode_off, 3)
      && $past(cpu_mode_off, 4) && $past(cpu_mode_off, 5))
      |-> (cpu_clk_o == '1));

  // R6
  pci_mode_ignore_chk: assert property (@(negedge pci_clk_i) disable iff (!rst_n || !pwr_dn_n)
    (pci_mode_off && $past(pci_mode_off, 1) && $past(pci_mode_off, 2) && $past(pci_mode_off, 3)
      && $past(pci_mode_off, 4))
      |-> (pci_clk_o == '1));

  // R7
  cpu_pwr_dn_chk: assert property (@(negedge cpu_clk_i) disable iff (!rst_n)
    !pwr_dn_n |-> (cpu_clk_o == '0));

  // R7
  pci_pwr_dn_chk: assert property (@(negedge pci_clk_i) disable iff (!rst_n)
    !pwr_dn_n |-> ((pci_clk_o == '0) && !pci_free_o));

  // R9
  cpu_low_phase_chk: assert property (@(posedge cpu_clk_i) disable iff (!rst_n)
    cpu_clk_o == '0);

  // R9
  pci_low_phase_chk: assert property (@(posedge pci_clk_i) disable iff (!rst_n)
    (pci_clk_o == '0) && !pci_free_o);

endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk #(.NUM_CPU(NUM_CPU), .NUM_PCI(NUM_PCI)) u_chk (
  .cpu_clk_i  (cpu_clk_i),
  .pci_clk_i  (pci_clk_i),
  .rst_n      (rst_n),
  .pwr_dn_n   (pwr_dn_n),
  .mode_n     (mode_n),
  .cpu_stop_n (cpu_stop_n),
  .pci_stop_n (pci_stop_n),
  .cpu_clk_o  (cpu_clk_o),
  .pci_clk_o  (pci_clk_o),
  .pci_free_o (pci_free_o)
);

// File: tb/tb_clk_stop_ctrl.sv
`timescale 1ns/100ps
module tb_clk_stop_ctrl;

  localparam int NUM_CPU = 4;
  localparam int NUM_PCI = 6;

  logic cpu_clk;
  logic pci_clk;
  logic rst_n;
  logic pwr_dn_n;
  logic mode_n;
  logic cpu_stop_n;
  logic pci_stop_n;
  logic [NUM_CPU-1:0] cpu_clk_o;
  logic [NUM_PCI-1:0] pci_clk_o;
  logic pci_free_o;
  logic osc_off_o;

  int nchk;
  int nerr;
  bit done;

  clk_stop_ctrl #(.NUM_CPU(NUM_CPU), .NUM_PCI(NUM_PCI)) dut (
    .cpu_clk_i  (cpu_clk),
    .pci_clk_i  (pci_clk),
    .rst_n      (rst_n),
    .pwr_dn_n   (pwr_dn_n),
    .mode_n     (mode_n),
    .cpu_stop_n (cpu_stop_n),
    .pci_stop_n (pci_stop_n),
    .cpu_clk_o  (cpu_clk_o),
    .pci_clk_o  (pci_clk_o),
    .pci_free_o (pci_free_o),
    .osc_off_o  (osc_off_o)
  );

  // 250 MHz CPU clock, PCI clock at half that rate.
  initial begin
    cpu_clk = 1'b0;
    forever #2 cpu_clk = ~cpu_clk;
  end

  initial begin
    pci_clk = 1'b0;
    forever #4 pci_clk = ~pci_clk;
  end

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Count CPU pulses over n rising edges; also count malformed phases.
  task automatic count_cpu(input int n, output int pulses, output int bad);
    logic [NUM_CPU-1:0] a;
    logic [NUM_CPU-1:0] b;
    logic [NUM_CPU-1:0] c;
    pulses = 0;
    bad    = 0;
    repeat (n) begin
      @(posedge cpu_clk);
      #0.5 a = cpu_clk_o;
      #1   b = cpu_clk_o;
      #1.5 c = cpu_clk_o;
      if (a == '1) pulses++;
      if (a != b || c != '0 || (a != '0 && a != '1)) bad++;
    end
  endtask

  task automatic count_pci(input int n, output int gated, output int free, output int bad);
    logic [NUM_PCI-1:0] a;
    logic [NUM_PCI-1:0] b;
    logic [NUM_PCI-1:0] c;
    logic fa;
    logic fb;
    logic fc;
    gated = 0;
    free  = 0;
    bad   = 0;
    repeat (n) begin
      @(posedge pci_clk);
      #1 begin a = pci_clk_o; fa = pci_free_o; end
      #2 begin b = pci_clk_o; fb = pci_free_o; end
      #3 begin c = pci_clk_o; fc = pci_free_o; end
      if (a == '1) gated++;
      if (fa) free++;
      if (a != b || c != '0 || (a != '0 && a != '1)) bad++;
      if (fa != fb || fc) bad++;
    end
  endtask

  task automatic after_cpu_edge();
    @(posedge cpu_clk);
    #0.2;
  endtask

  task automatic after_pci_edge();
    @(posedge pci_clk);
    #0.2;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int p;
    int g;
    int f;
    int bad;
    nchk = 0;
    nerr = 0;
    done = 1'b0;
    rst_n      = 1'b0;
    pwr_dn_n   = 1'b1;
    mode_n     = 1'b1;
    cpu_stop_n = 1'b1;
    pci_stop_n = 1'b1;

    // R1: reset state
    count_cpu(4, p, bad);
    check("R1 cpu pulses in reset", p, 0);
    count_pci(3, g, f, bad);
    check("R1 pci pulses in reset", g, 0);
    check("R1 free pulses in reset", f, 0);
    check("R1 osc flag in reset", int'(osc_off_o), 0);

    // R1: release, first pulse on 5th edge -> 4 pulses in 8 edges
    after_cpu_edge();
    rst_n = 1'b1;
    count_cpu(8, p, bad);
    check("R1 cpu pulses after reset", p, 4);
    check("R9 cpu shape after reset", bad, 0);
    repeat (6) @(posedge pci_clk);

    // R3: CPU stop latency, mode enabled
    mode_n = 1'b0;
    repeat (6) @(posedge pci_clk);
    after_cpu_edge();
    cpu_stop_n = 1'b0;
    count_cpu(8, p, bad);
    check("R3 cpu pulses after stop", p, 2);
    check("R9 cpu shape on stop", bad, 0);
    // R2: stays stopped
    count_cpu(8, p, bad);
    check("R2 cpu held low", p, 0);
    count_pci(4, g, f, bad);
    check("R2 pci unaffected by cpu stop", g, 4);
    after_cpu_edge();
    cpu_stop_n = 1'b1;
    count_cpu(8, p, bad);
    check("R3 cpu pulses after restart", p, 6);
    check("R9 cpu shape on restart", bad, 0);

    // R5: PCI stop latency
    after_pci_edge();
    pci_stop_n = 1'b0;
    count_pci(4, g, f, bad);
    check("R5 pci pulses after stop", g, 1);
    check("R4 free during stop edge", f, 4);
    check("R9 pci shape on stop", bad, 0);
    // R4: gated low, free running
    count_pci(6, g, f, bad);
    check("R4 pci held low", g, 0);
    check("R4 free keeps running", f, 6);
    count_cpu(4, p, bad);
    check("R4 cpu unaffected by pci stop", p, 4);
    after_pci_edge();
    pci_stop_n = 1'b1;
    count_pci(4, g, f, bad);
    check("R5 pci pulses after restart", g, 3);
    check("R9 pci shape on restart", bad, 0);

    // R6: mode high ignores both stops
    mode_n = 1'b1;
    repeat (6) @(posedge pci_clk);
    cpu_stop_n = 1'b0;
    pci_stop_n = 1'b0;
    repeat (6) @(posedge pci_clk);
    count_cpu(8, p, bad);
    check("R6 cpu ignores stop", p, 8);
    count_pci(4, g, f, bad);
    check("R6 pci ignores stop", g, 4);
    mode_n = 1'b0;
    repeat (6) @(posedge pci_clk);
    count_cpu(4, p, bad);
    check("R6 cpu stop live once mode low", p, 0);
    count_pci(4, g, f, bad);
    check("R6 pci stop live once mode low", g, 0);

    // R7: power-down overrides everything
    pwr_dn_n   = 1'b0;
    cpu_stop_n = 1'b1;
    pci_stop_n = 1'b1;
    mode_n     = 1'b1;
    repeat (6) @(posedge pci_clk);
    count_cpu(8, p, bad);
    check("R7 cpu low in power-down", p, 0);
    count_pci(4, g, f, bad);
    check("R7 pci low in power-down", g, 0);
    check("R7 free low in power-down", f, 0);
    check("R7 osc flag set", int'(osc_off_o), 1);
    check("R9 pci shape in power-down", bad, 0);

    // R8: CPU restart after power-down
    after_cpu_edge();
    pwr_dn_n = 1'b1;
    count_cpu(8, p, bad);
    check("R8 cpu pulses after power-up", p, 4);
    check("R7 osc flag cleared", int'(osc_off_o), 0);

    // R8: PCI restart after power-down
    pwr_dn_n = 1'b0;
    repeat (6) @(posedge pci_clk);
    after_pci_edge();
    pwr_dn_n = 1'b1;
    count_pci(4, g, f, bad);
    check("R8 pci pulses after power-up", g, 1);
    check("R8 free pulses after power-up", f, 1);
    check("R9 pci shape after power-up", bad, 0);

    // Sweep: power, mode and both stops; expectations from R2 R4 R6 R7
    for (int code = 0; code < 16; code++) begin
      int pd;
      int md;
      int cs;
      int ps;
      int exp_cpu;
      int exp_pci;
      int exp_free;
      pd = (code >> 3) & 1;
      md = (code >> 2) & 1;
      cs = (code >> 1) & 1;
      ps = code & 1;
      pwr_dn_n   = pd[0];
      mode_n     = md[0];
      cpu_stop_n = cs[0];
      pci_stop_n = ps[0];
      repeat (6) @(posedge pci_clk);
      exp_cpu  = (pd == 1 && (md == 1 || cs == 1)) ? 4 : 0;
      exp_pci  = (pd == 1 && (md == 1 || ps == 1)) ? 2 : 0;
      exp_free = (pd == 1) ? 2 : 0;
      count_cpu(4, p, bad);
      check("R2 R6 R7 sweep cpu", p, exp_cpu);
      check("R9 sweep cpu shape", bad, 0);
      count_pci(2, g, f, bad);
      check("R4 R6 R7 sweep pci", g, exp_pci);
      check("R4 R7 sweep free", f, exp_free);
      check("R9 sweep pci shape", bad, 0);
      check("R7 sweep osc flag", int'(osc_off_o), 1 - pd);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule